// File: doc/BRIEF.md
# Flash Channel Command-Priority Arbiter

This block shares one byte-wide flash package bus among several planes. Every plane carries two data registers. It can therefore take its next operation while it is still returning the result of the previous one. Two kinds of transfer compete for the bus: single-beat command transfers from the controller's command queue, and multi-beat read-data bursts from planes that have data ready. At every arbitration point a command wins over return data. The target plane can then start its next access while its earlier result drains. Return data is never starved, because a run of back-to-back commands is capped.

The controller is a two-state machine. In ARBITRATE it picks a transfer for the current cycle. A command grant (transition CMD_GRANT) stays in ARBITRATE. The first beat of a data burst (transition BURST_OPEN) moves to STREAM. When no transfer is eligible (transition HOLD_IDLE) it stays in ARBITRATE with the bus idle. In STREAM the remaining beats of the burst go to the same plane. On the final beat (transition BURST_CLOSE) it returns to ARBITRATE. Grants are combinational on the current requests, and each grant covers one bus beat in that cycle.

Top module: `flash_chan_arbiter`

## Requirements
- R1: While reset is asserted, no grant is given: bus_valid, cmd_ack and every rd_ack bit are 0.
- R2: At most one grant is given per cycle. bus_valid is 1 exactly when a grant is given. bus_owner is the plane index (0 to NUM_PLANES-1) for a data beat and the value NUM_PLANES for a command beat. A command is a single beat, with bus_last set to 1.
- R3: At an arbitration point, an eligible command is granted ahead of any pending return data, unless R7 forces data.
- R4: A command whose target plane has pl_full set is not granted. In that cycle, pending data may take the bus; with no data pending, the bus is idle.
- R5: A data burst is exactly BURST_BEATS consecutive beats to the same plane. It is never split or preempted by a command, and bus_last is 1 only on its final beat.
- R6: A new burst goes to the first requesting plane, searching upward with wrap-around from a pointer. The pointer is plane 0 after reset and moves to the plane after the one last served.
- R7: After CMD_RUN_MAX consecutive command grants, if any plane requests data, the next arbitration point opens a data burst. Opening a burst clears the command-run count.
- R8: bus_data carries cmd_byte on a command beat and byte p of rd_data (bits 8p+7 down to 8p) on a data beat from plane p.
- R9: In ARBITRATE with neither an eligible command nor a data request, the bus stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_req | input | 1 | A command byte is waiting |
| cmd_plane | input | $clog2(NUM_PLANES) | Plane addressed by the waiting command |
| cmd_byte | input | DW | Command byte to drive on the bus |
| cmd_ack | output | 1 | Command granted this cycle |
| pl_full | input | NUM_PLANES | Plane has both registers occupied |
| rd_req | input | NUM_PLANES | Plane has return data ready |
| rd_data | input | NUM_PLANES*DW | Current return byte of each plane |
| rd_ack | output | NUM_PLANES | One return beat taken from the plane this cycle |
| bus_data | output | DW | Shared bus byte |
| bus_valid | output | 1 | Bus carries a beat this cycle |
| bus_last | output | 1 | Final beat of the current transfer |
| bus_owner | output | $clog2(NUM_PLANES+1) | Plane index or NUM_PLANES for the command source |

## Verification
The properties assume that a plane keeps rd_req high until its whole burst has been taken. A plane does not drop out part-way through the beats it was granted. The bench only raises or lowers rd_req between bursts, or holds it steady across a scenario. The properties also assume that cmd_plane names a valid plane, and every stimulus pattern stays inside the plane range.

// File: rtl/flash_chan_arb_pkg.sv
package flash_chan_arb_pkg;

    typedef enum logic [0:0] {
        ST_ARB    = 1'b0,
        ST_STREAM = 1'b1
    } arb_state_e;

endpackage

// File: rtl/fca_rr_pick.sv
module fca_rr_pick #(
    parameter int N  = 4,
    localparam int PW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic          found,
    output logic [PW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            int j;
            j = (int'(ptr) + i) % N;
            if (!found && req[j]) begin
                found = 1'b1;
                idx   = PW'(j);
            end
        end
    end

endmodule

// File: rtl/fca_beat_ctr.sv
module fca_beat_ctr #(
    parameter int BEATS = 4,
    localparam int CW = $clog2(BEATS) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic step,
    output logic at_last
);

    logic [CW-1:0] cnt;

    assign at_last = (cnt == CW'(BEATS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(1);
        end else if (step) begin
            cnt <= at_last ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fca_run_ctr.sv
module fca_run_ctr #(
    parameter int MAXR = 3,
    localparam int RW = $clog2(MAXR + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic clr,
    output logic at_limit
);

    logic [RW-1:0] cnt;

    assign at_limit = (cnt >= RW'(MAXR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && !at_limit) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/flash_chan_arbiter.sv
module flash_chan_arbiter
    import flash_chan_arb_pkg::*;
#(
    parameter int NUM_PLANES  = 4,
    parameter int BURST_BEATS = 4,
    parameter int CMD_RUN_MAX = 3,
    parameter int DW          = 8,
    localparam int PW = $clog2(NUM_PLANES),
    localparam int OW = $clog2(NUM_PLANES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_req,
    input  logic [PW-1:0]            cmd_plane,
    input  logic [DW-1:0]            cmd_byte,
    output logic                     cmd_ack,
    input  logic [NUM_PLANES-1:0]    pl_full,
    input  logic [NUM_PLANES-1:0]    rd_req,
    input  logic [NUM_PLANES*DW-1:0] rd_data,
    output logic [NUM_PLANES-1:0]    rd_ack,
    output logic [DW-1:0]            bus_data,
    output logic                     bus_valid,
    output logic                     bus_last,
    output logic [OW-1:0]            bus_owner
);

    localparam bit SINGLE_BEAT = (BURST_BEATS == 1);

    arb_state_e    state, nxt_state;
    logic [PW-1:0] cur_plane;
    logic [PW-1:0] rr_ptr;
    logic          pick_found;
    logic [PW-1:0] pick_idx;
    logic          beat_last;
    logic          run_limit;
    logic          burst_start;
    logic          beat_step;
    logic          cmd_grant;
    logic          cmd_ok;
    logic          force_data;

    assign cmd_ok     = cmd_req && !pl_full[cmd_plane];
    assign force_data = run_limit && (|rd_req);

    fca_rr_pick #(.N(NUM_PLANES)) u_pick (
        .req   (rd_req),
        .ptr   (rr_ptr),
        .found (pick_found),
        .idx   (pick_idx)
    );

    fca_beat_ctr #(.BEATS(BURST_BEATS)) u_beats (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (burst_start),
        .step    (beat_step),
        .at_last (beat_last)
    );

    fca_run_ctr #(.MAXR(CMD_RUN_MAX)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (cmd_grant),
        .clr      (burst_start),
        .at_limit (run_limit)
    );

    // state register and burst bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_ARB;
            cur_plane <= '0;
            rr_ptr    <= '0;
        end else begin
            state <= nxt_state;
            if (burst_start) begin
                cur_plane <= pick_idx;
                rr_ptr    <= (pick_idx == PW'(NUM_PLANES - 1)) ? '0 : pick_idx + 1'b1;
            end
        end
    end

    // next state and grant outputs
    always_comb begin
        nxt_state   = state;
        cmd_ack     = 1'b0;
        rd_ack      = '0;
        bus_valid   = 1'b0;
        bus_last    = 1'b0;
        bus_owner   = '0;
        bus_data    = '0;
        burst_start = 1'b0;
        beat_step   = 1'b0;
        cmd_grant   = 1'b0;
        if (rst_n) begin
            unique case (state)
                ST_ARB: begin
                    if (cmd_ok && !force_data) begin
                        // CMD_GRANT
                        cmd_ack   = 1'b1;
                        cmd_grant = 1'b1;
                        bus_valid = 1'b1;
                        bus_last  = 1'b1;
                        bus_owner = OW'(NUM_PLANES);
                        bus_data  = cmd_byte;
                    end else if (pick_found) begin
                        // BURST_OPEN
                        rd_ack[pick_idx] = 1'b1;
                        bus_valid        = 1'b1;
                        bus_owner        = OW'(pick_idx);
                        bus_data         = rd_data[pick_idx*DW +: DW];
                        burst_start      = 1'b1;
                        if (SINGLE_BEAT) bus_last = 1'b1;
                        else             nxt_state = ST_STREAM;
                    end
                    // otherwise HOLD_IDLE
                end
                ST_STREAM: begin
                    rd_ack[cur_plane] = 1'b1;
                    bus_valid         = 1'b1;
                    bus_owner         = OW'(cur_plane);
                    bus_data          = rd_data[cur_plane*DW +: DW];
                    beat_step         = 1'b1;
                    if (beat_last) begin
                        // BURST_CLOSE
                        bus_last  = 1'b1;
                        nxt_state = ST_ARB;
                    end
                end
                default: nxt_state = ST_ARB;
            endcase
        end
    end

endmodule

// File: rtl/fca_checker.sv
module fca_checker #(
    parameter int NUM_PLANES  = 4,
    parameter int CMD_RUN_MAX = 3,
    localparam int PW = $clog2(NUM_PLANES),
    localparam int OW = $clog2(NUM_PLANES + 1),
    localparam int RW = $clog2(CMD_RUN_MAX + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_req,
    input logic [PW-1:0]         cmd_plane,
    input logic [NUM_PLANES-1:0] pl_full,
    input logic [NUM_PLANES-1:0] rd_req,
    input logic                  cmd_ack,
    input logic [NUM_PLANES-1:0] rd_ack,
    input logic                  bus_valid,
    input logic                  bus_last,
    input logic [OW-1:0]         bus_owner
);

    logic          at_bnd;
    logic [RW-1:0] chk_run;
    logic          data_beat;

    assign data_beat = bus_valid && (bus_owner != OW'(NUM_PLANES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            at_bnd  <= 1'b1;
            chk_run <= '0;
        end else begin
            at_bnd <= !(data_beat && !bus_last);
            if (data_beat)
                chk_run <= '0;
            else if (cmd_ack && chk_run < RW'(CMD_RUN_MAX))
                chk_run <= chk_run + 1'b1;
        end
    end

    p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_ack, rd_ack}) && (bus_valid == (cmd_ack || (|rd_ack))));

    p_cmd_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (at_bnd && cmd_req && !pl_full[cmd_plane] &&
         (chk_run < RW'(CMD_RUN_MAX) || !(|rd_req))) |-> cmd_ack);

    p_full_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ack |-> !pl_full[cmd_plane]);

    p_burst_whole_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_beat && !bus_last) |=> (bus_valid && bus_owner == $past(bus_owner)));

    p_ack_to_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack & ~rd_req) == '0);

    p_force_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (at_bnd && chk_run >= RW'(CMD_RUN_MAX) && (|rd_req)) |-> (!cmd_ack && bus_valid));

endmodule

bind flash_chan_arbiter fca_checker #(
    .NUM_PLANES  (NUM_PLANES),
    .CMD_RUN_MAX (CMD_RUN_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_req   (cmd_req),
    .cmd_plane (cmd_plane),
    .pl_full   (pl_full),
    .rd_req    (rd_req),
    .cmd_ack   (cmd_ack),
    .rd_ack    (rd_ack),
    .bus_valid (bus_valid),
    .bus_last  (bus_last),
    .bus_owner (bus_owner)
);

// File: tb/flash_chan_arbiter_tb.sv
module flash_chan_arbiter_tb;

    localparam int N  = 4;
    localparam int BB = 4;
    localparam int CR = 3;
    localparam int DW = 8;
    localparam int PW = $clog2(N);
    localparam int OW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmd_req;
    logic [PW-1:0] cmd_plane;
    logic [DW-1:0] cmd_byte;
    logic          cmd_ack;
    logic [N-1:0]  pl_full;
    logic [N-1:0]  rd_req;
    logic [N*DW-1:0] rd_data;
    logic [N-1:0]  rd_ack;
    logic [DW-1:0] bus_data;
    logic          bus_valid;
    logic          bus_last;
    logic [OW-1:0] bus_owner;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    flash_chan_arbiter #(
        .NUM_PLANES(N), .BURST_BEATS(BB), .CMD_RUN_MAX(CR), .DW(DW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_plane(cmd_plane),
        .cmd_byte(cmd_byte), .cmd_ack(cmd_ack), .pl_full(pl_full),
        .rd_req(rd_req), .rd_data(rd_data), .rd_ack(rd_ack),
        .bus_data(bus_data), .bus_valid(bus_valid), .bus_last(bus_last),
        .bus_owner(bus_owner)
    );

    function automatic logic [7:0] pbyte(input int p);
        return 8'hA0 + 8'(p);
    endfunction

    task automatic exp_cyc(input string rq, input bit v, input int own,
                           input bit lst, input logic [7:0] dat);
        logic [N-1:0] ea;
        bit ec;
        bit bad;
        ea = '0;
        ec = v && (own == N);
        if (v && own < N) ea[own] = 1'b1;
        bad = (bus_valid !== v) || (cmd_ack !== ec) || (rd_ack !== ea);
        if (v) bad = bad || (bus_owner !== OW'(own)) || (bus_last !== lst) || (bus_data !== dat);
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s: got valid=%0b owner=%0d last=%0b data=%02h cmd_ack=%0b rd_ack=%b; expected valid=%0b owner=%0d last=%0b data=%02h cmd_ack=%0b rd_ack=%b",
                     rq, bus_valid, bus_owner, bus_last, bus_data, cmd_ack, rd_ack,
                     v, own, lst, dat, ec, ea);
        end
    endtask

    task automatic do_reset;
        rst_n = 1'b0; cmd_req = 1'b0; cmd_plane = '0; cmd_byte = '0;
        pl_full = '0; rd_req = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cyc;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rd_data = {pbyte(3), pbyte(2), pbyte(1), pbyte(0)};
        do_reset();

        // R1: requests present while reset held
        rst_n = 1'b0; cmd_req = 1'b1; rd_req = 4'b1111;
        #5; exp_cyc("R1", 0, 0, 0, 8'h00);
        do_reset();

        // R2 R8: lone command
        cyc(); cmd_req = 1'b1; cmd_plane = 2'd2; cmd_byte = 8'h5A;
        #5; exp_cyc("R2", 1, N, 1, 8'h5A);

        // R3 R5 R9: command beats data, burst is not preempted
        do_reset();
        cyc(); cmd_req = 1'b1; cmd_plane = 2'd0; cmd_byte = 8'h11; rd_req = 4'b0010;
        #5; exp_cyc("R3", 1, N, 1, 8'h11);
        cyc(); cmd_req = 1'b0;
        #5; exp_cyc("R3", 1, 1, 0, pbyte(1));
        cyc(); cmd_req = 1'b1; cmd_byte = 8'h22;
        #5; exp_cyc("R5", 1, 1, 0, pbyte(1));
        cyc(); #5; exp_cyc("R5", 1, 1, 0, pbyte(1));
        cyc(); #5; exp_cyc("R5", 1, 1, 1, pbyte(1));
        cyc(); rd_req = '0;
        #5; exp_cyc("R3", 1, N, 1, 8'h22);
        cyc(); cmd_req = 1'b0;
        #5; exp_cyc("R9", 0, 0, 0, 8'h00);

        // R4: full plane masked, data proceeds, then idle when nothing else
        do_reset();
        cyc(); cmd_req = 1'b1; cmd_plane = 2'd2; cmd_byte = 8'h33;
        pl_full = 4'b0100; rd_req = 4'b1000;
        #5; exp_cyc("R4", 1, 3, 0, pbyte(3));
        for (int k = 1; k < BB; k++) begin
            cyc(); #5; exp_cyc("R5", 1, 3, k == BB - 1, pbyte(3));
        end
        cyc(); rd_req = '0;
        #5; exp_cyc("R4", 0, 0, 0, 8'h00);
        cyc(); pl_full = '0;
        #5; exp_cyc("R4", 1, N, 1, 8'h33);

        // R6: round robin with all planes requesting
        do_reset();
        cmd_req = 1'b0;
        for (int k = 0; k < 5 * BB; k++) begin
            cyc(); rd_req = 4'b1111;
            #5; exp_cyc("R6", 1, (k / BB) % N, (k % BB) == BB - 1, pbyte((k / BB) % N));
        end
        // pointer now at plane 1; requests from planes 1 and 3 alternate
        for (int k = 0; k < 3 * BB; k++) begin
            int p;
            p = ((k / BB) % 2 == 0) ? 1 : 3;
            cyc(); rd_req = 4'b1010;
            #5; exp_cyc("R6", 1, p, (k % BB) == BB - 1, pbyte(p));
        end

        // R7: command stream is capped, one burst forced per cap
        do_reset();
        for (int k = 0; k < 2 * (CR + BB); k++) begin
            int ph;
            ph = k % (CR + BB);
            cyc(); cmd_req = 1'b1; cmd_plane = 2'd0; cmd_byte = 8'h77; rd_req = 4'b0100;
            #5;
            if (ph < CR) exp_cyc("R7", 1, N, 1, 8'h77);
            else         exp_cyc("R7", 1, 2, (ph - CR) == BB - 1, pbyte(2));
        end

        // R4 R8: sweep every target plane against every full mask, no data
        do_reset();
        for (int m = 0; m < (1 << N); m++) begin
            for (int p = 0; p < N; p++) begin
                cyc(); cmd_req = 1'b1; cmd_plane = PW'(p); pl_full = N'(m);
                cmd_byte = 8'(m * 16 + p); rd_req = '0;
                #5;
                if (m[p]) exp_cyc("R4", 0, 0, 0, 8'h00);
                else      exp_cyc("R8", 1, N, 1, 8'(m * 16 + p));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule